// File: doc/BRIEF.md
# Watchdog and Periodic-Timer Clock Source Selector

This block holds the software-visible selection of which clock drives two timers elsewhere on the chip: a periodic interrupt timer and a watchdog. Software writes a byte-wide configuration word. The block turns the select bits into encoded source outputs for the clock multiplexers. It also emits one-cycle restart pulses, which tell each timer to begin a fresh time-out period whenever the clock it is actually running from changes.

Two of the select bits may pick the external oscillator. Such a bit can only be set while the oscillator-qualified status input is high. It is cleared by hardware as soon as that input falls. The watchdog has a second, ungated select bit that picks an auxiliary clock and masks the oscillator bit. A change that the mask hides does not count as a source change and raises no restart pulse. The multiplexers, the timers and the oscillator monitor sit outside the block.

Top module: `clk_src_sel`

## Requirements
- R1: After reset the configuration word reads 0, both timers select the internal RC clock (timer source 0, watchdog source code 00) and neither restart output is high.
- R2: The word is laid out as bit 0 = watchdog oscillator select, bit 1 = timer oscillator select, bit 2 = watchdog auxiliary select. Bits 7..3 always read 0. A write takes effect at the next clock edge and is visible on the read port from then on.
- R3: A write sets the timer select bit to 1 only if the oscillator-qualified input is 1 in that cycle. If the input is 0, the bit stays 0.
- R4: In any cycle where the oscillator-qualified input is 0, the timer select bit is 0 after the next edge, whatever is written.
- R5: The timer source output equals the timer select bit (0 = RC clock, 1 = oscillator). The timer restart output is high for exactly the one cycle in which a changed timer source first appears, whether a write or the automatic clear caused the change.
- R6: The watchdog source output is encoded as 00 = RC clock (aux 0, osc 0), 01 = oscillator (aux 0, osc 1) and 10 = auxiliary clock (aux 1, osc either value). Code 11 never appears.
- R7: The watchdog oscillator select bit follows the same gating as R3 and R4: it is set only while the oscillator is qualified, and it is cleared whenever the qualified input is 0.
- R8: While the auxiliary select bit is 1 both before and after an edge, a change of the watchdog oscillator bit leaves the watchdog source at 10 and raises no watchdog restart.
- R9: While the auxiliary select bit is 0, a change of the watchdog oscillator bit changes the source and raises the watchdog restart for one cycle, aligned with the new source code.
- R10: Writing the value already held, or a set request blocked by the oscillator gating, raises no restart pulse.
- R11: The auxiliary select bit is written regardless of the oscillator status. Changing it changes the watchdog source and raises the watchdog restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 8 | Configuration write data |
| oscReady | input | 1 | Oscillator-qualified status |
| rdData | output | 8 | Current configuration word |
| timerSrc | output | 1 | Timer clock source, 0 = RC, 1 = oscillator |
| wdogSrc | output | 2 | Watchdog clock source code |
| timerRestart | output | 1 | One-cycle timer time-out restart |
| wdogRestart | output | 1 | One-cycle watchdog time-out restart |

## Verification
A wrong select bit shows on the read port and on the source outputs one clock after the write or the oscillator drop that caused it. A wrong restart decision shows as a missing or extra pulse in that same cycle, so each step is compared one edge after it is driven. The bench sweeps every write value against both oscillator states. This exposes a lost mask, a missing gate, or a pulse taken from the raw bit instead of the decoded source.

// File: rtl/clk_src_sel_pkg.sv
package clk_src_sel_pkg;

  typedef enum logic [1:0] {
    SRC_RC  = 2'b00,
    SRC_OSC = 2'b01,
    SRC_AUX = 2'b10
  } wdogSrc_e;

  typedef struct packed {
    logic load;      // software write this cycle
    logic allowSet;  // gated bits may be set
    logic dropOsc;   // oscillator lost: clear gated bits
  } selStrobe_t;

  function automatic wdogSrc_e decodeWdog(input logic auxSel, input logic oscSel);
    if (auxSel) return SRC_AUX;
    else if (oscSel) return SRC_OSC;
    else return SRC_RC;
  endfunction

endpackage

// File: rtl/clk_src_sel_ctrl.sv
module clk_src_sel_ctrl
  import clk_src_sel_pkg::*;
(
  input  logic       wrEn,
  input  logic       oscReady,
  output selStrobe_t strobe
);

  always_comb begin
    strobe.load     = wrEn;
    strobe.allowSet = oscReady;
    strobe.dropOsc  = !oscReady;
  end

endmodule

// File: rtl/clk_src_sel_dp.sv
module clk_src_sel_dp
  import clk_src_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMER_BIT   = 1,
  parameter int WDOG_LO_BIT = 0,
  parameter int WDOG_HI_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oscReady,
  output logic [DATA_W-1:0] cfgWord,
  output logic              timerSrc,
  output logic [1:0]        wdogSrc,
  output logic              timerRestart,
  output logic              wdogRestart
);

  logic [DATA_W-1:0] cfgNext;

  // One next-state cell per word bit; the variant depends on the bit's role.
  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    if (i == TIMER_BIT || i == WDOG_LO_BIT) begin : gGated
      always_comb begin
        if (strobe.dropOsc)    cfgNext[i] = 1'b0;
        else if (strobe.load)  cfgNext[i] = wrData[i] & strobe.allowSet;
        else                   cfgNext[i] = cfgWord[i];
      end
    end else if (i == WDOG_HI_BIT) begin : gFree
      always_comb cfgNext[i] = strobe.load ? wrData[i] : cfgWord[i];
    end else begin : gZero
      always_comb cfgNext[i] = 1'b0;
    end
  end

  wdogSrc_e wdogCur, wdogNext;
  always_comb begin
    wdogCur  = decodeWdog(cfgWord[WDOG_HI_BIT], cfgWord[WDOG_LO_BIT]);
    wdogNext = decodeWdog(cfgNext[WDOG_HI_BIT], cfgNext[WDOG_LO_BIT]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord      <= '0;
      timerRestart <= 1'b0;
      wdogRestart  <= 1'b0;
    end else begin
      cfgWord      <= cfgNext;
      timerRestart <= cfgNext[TIMER_BIT] != cfgWord[TIMER_BIT];
      wdogRestart  <= wdogNext != wdogCur;
    end
  end

  assign timerSrc = cfgWord[TIMER_BIT];
  assign wdogSrc  = wdogCur;

  AST_TIMER_SET_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgWord[TIMER_BIT]) |-> $past(oscReady)); // R3
  AST_TIMER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !oscReady |=> !cfgWord[TIMER_BIT]); // R4
  AST_TIMER_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[TIMER_BIT] != $past(cfgWord[TIMER_BIT])) |-> timerRestart); // R5
  AST_TIMER_PULSE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    timerRestart |-> (cfgWord[TIMER_BIT] != $past(cfgWord[TIMER_BIT]))); // R5
  AST_WDOG_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    wdogSrc != 2'b11); // R6
  AST_WDOG_LO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !oscReady |=> !cfgWord[WDOG_LO_BIT]); // R7
  AST_AUX_MASKS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[WDOG_HI_BIT] && $past(cfgWord[WDOG_HI_BIT])) |-> !wdogRestart); // R8
  AST_LO_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWord[WDOG_HI_BIT] && !$past(cfgWord[WDOG_HI_BIT])
     && (cfgWord[WDOG_LO_BIT] != $past(cfgWord[WDOG_LO_BIT]))) |-> wdogRestart); // R9
  AST_AUX_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[WDOG_HI_BIT] != $past(cfgWord[WDOG_HI_BIT])) |-> wdogRestart); // R11

endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import clk_src_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMER_BIT   = 1,
  parameter int WDOG_LO_BIT = 0,
  parameter int WDOG_HI_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oscReady,
  output logic [DATA_W-1:0] rdData,
  output logic              timerSrc,
  output logic [1:0]        wdogSrc,
  output logic              timerRestart,
  output logic              wdogRestart
);

  selStrobe_t strobe;

  clk_src_sel_ctrl uCtrl (
    .wrEn     (wrEn),
    .oscReady (oscReady),
    .strobe   (strobe)
  );

  clk_src_sel_dp #(
    .DATA_W      (DATA_W),
    .TIMER_BIT   (TIMER_BIT),
    .WDOG_LO_BIT (WDOG_LO_BIT),
    .WDOG_HI_BIT (WDOG_HI_BIT)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .oscReady     (oscReady),
    .cfgWord      (rdData),
    .timerSrc     (timerSrc),
    .wdogSrc      (wdogSrc),
    .timerRestart (timerRestart),
    .wdogRestart  (wdogRestart)
  );

endmodule

// File: tb/sim_clk_src_sel.sv
`timescale 1ns/1ps
module sim_clk_src_sel;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       oscReady = 1'b0;
  logic [7:0] rdData;
  logic       timerSrc;
  logic [1:0] wdogSrc;
  logic       timerRestart;
  logic       wdogRestart;

  always #4 clk = ~clk;  // 125 MHz

  clk_src_sel u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .oscReady(oscReady),
    .rdData(rdData), .timerSrc(timerSrc), .wdogSrc(wdogSrc),
    .timerRestart(timerRestart), .wdogRestart(wdogRestart)
  );

  typedef struct {
    logic [7:0] rd;
    logic       tSrc;
    logic [1:0] wSrc;
    logic       tPulse;
    logic       wPulse;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  logic mT = 1'b0, mLo = 1'b0, mHi = 1'b0;

  function automatic logic [1:0] wCode(input logic hi, input logic lo);
    return hi ? 2'b10 : {1'b0, lo};
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what must appear after the edge.
  task automatic step(input logic we, input logic [7:0] d, input logic osc, input string tag);
    expItem_t e;
    logic nT, nLo, nHi;
    @(negedge clk);
    wrEn = we; wrData = d; oscReady = osc;
    nT  = !osc ? 1'b0 : (we ? d[1] : mT);
    nLo = !osc ? 1'b0 : (we ? d[0] : mLo);
    nHi = we ? d[2] : mHi;
    e.rd = {5'b0, nHi, nT, nLo};
    e.tSrc = nT;
    e.wSrc = wCode(nHi, nLo);
    e.tPulse = nT != mT;
    e.wPulse = wCode(nHi, nLo) != wCode(mHi, mLo);
    e.tag = tag;
    mT = nT; mLo = nLo; mHi = nHi;
    @(posedge clk);
    #1 expQ.push_back(e);
  endtask

  // Monitor: compares each result one edge after its stimulus.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, "rdData", rdData, e.rd);
      check(e.tag, "timerSrc", {7'b0, timerSrc}, {7'b0, e.tSrc});
      check(e.tag, "wdogSrc", {6'b0, wdogSrc}, {6'b0, e.wSrc});
      check(e.tag, "timerRestart", {7'b0, timerRestart}, {7'b0, e.tPulse});
      check(e.tag, "wdogRestart", {7'b0, wdogRestart}, {7'b0, e.wPulse});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "rdData", rdData, 8'h00);
    check("R1", "src", {5'b0, timerSrc, wdogSrc}, 8'h00);
    check("R1", "pulses", {6'b0, timerRestart, wdogRestart}, 8'h00);
    rstN = 1'b1;
    step(1'b0, 8'h00, 1'b0, "R1");
    step(1'b1, 8'h02, 1'b0, "R3");   // blocked set, no pulse (R10)
    step(1'b1, 8'h02, 1'b1, "R3");   // set allowed, timer pulse
    step(1'b0, 8'h00, 1'b1, "R5");   // pulse lasts one cycle
    step(1'b1, 8'h02, 1'b1, "R10");  // same value, no pulse
    step(1'b0, 8'h00, 1'b0, "R4");   // oscillator lost, auto clear + pulse
    step(1'b1, 8'h03, 1'b1, "R9");   // watchdog to oscillator
    step(1'b1, 8'h02, 1'b1, "R9");   // back to RC, restart
    step(1'b1, 8'h06, 1'b1, "R11");  // aux select
    step(1'b1, 8'h07, 1'b1, "R8");   // low bit masked
    step(1'b1, 8'h06, 1'b1, "R8");
    step(1'b1, 8'h07, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, "R7");   // auto clear under aux: no wdog pulse
    step(1'b1, 8'hFF, 1'b1, "R2");   // upper bits read 0
    step(1'b1, 8'h01, 1'b0, "R7");   // blocked low set, aux removed
    step(1'b1, 8'h04, 1'b0, "R11");  // aux set while oscillator lost
    step(1'b1, 8'h00, 1'b1, "R6");
    step(1'b1, 8'h01, 1'b1, "R6");
    for (int o = 0; o < 2; o++) begin
      for (int v = 0; v < 8; v++) begin
        step(1'b1, 8'(v), o[0], "R6");
        step(1'b0, 8'h00, o[0], "R5");
      end
    end
    step(1'b0, 8'h00, 1'b1, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule